// File: doc/BRIEF.md
# SAR Converter Host Serial Controller

This block drives a 16-bit multichannel successive-approximation converter from the host side. When asked to convert, it raises the convert strobe for a set number of system clocks. It then waits for the converter's busy line to fall, with a timeout. After that it runs one serial frame of 24 SCK cycles. During the frame it shifts in the result, a start-of-sequence flag and the configuration the converter used for that result. In the same frame it can shift out a control word that reprograms the converter's channel, range and gain-compression settings for the following conversion.

SCK is derived from the system clock. Half an SCK period lasts a programmable number of system clocks. SDI changes only while SCK is low, so it is stable around every rising edge. The captured fields are presented together with a one-cycle valid pulse. After each frame a quiet interval must pass before the next convert strobe. A busy line that never falls raises a sticky error and returns the controller to idle.

Top module: `sar_host_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it: convert strobe low, SCK low, SDI low, valid low, error low, idle high, read-disable high.
- R2: A start request seen in idle raises the convert strobe on the next cycle and holds it high for exactly CNV_CYC system clocks.
- R3: SCK gives no rising edge while the convert strobe is high or before busy falls. A frame has exactly 24 rising SCK edges, spaced 2*SCK_HALF system clocks apart.
- R4: SDO is sampled at each rising SCK edge. Rising edges 1 to 16 give the result MSB first, edge 17 gives the start-of-sequence flag, and edges 18 to 24 give the 7-bit echoed configuration MSB first. All three appear together with a valid pulse lasting exactly one cycle.
- R5: With programming requested, SDI is 1 at rising edge 1, carries the 7 requested configuration bits MSB first at edges 2 to 8, and is 0 at edges 9 to 24. Without programming, SDI is 0 at all 24 edges, so the sequencer stays unchanged.
- R6: SDI changes only while SCK is low.
- R7: Start requests outside idle are ignored. The next convert strobe rises more than QUIET_CYC cycles after the valid pulse, even when start is held high.
- R8: If busy has not fallen BUSY_TMO cycles after the convert strobe ends, the error output rises, the controller returns to idle and no valid pulse is produced. Error clears when the next start is accepted.
- R9: Read-disable is low at every rising SCK edge and high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, taken only in idle |
| prog_i | input | 1 | Send a programming word in the coming frame |
| cfg_i | input | 7 | Configuration bits to program, MSB first |
| busy_i | input | 1 | Converter busy |
| sdo_i | input | 1 | Serial data from converter |
| cnv_o | output | 1 | Convert strobe |
| sck_o | output | 1 | Serial clock |
| sdi_o | output | 1 | Serial data to converter |
| rd_dis_o | output | 1 | Read-disable, low during the frame |
| idle_o | output | 1 | Controller idle |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | 16 | Conversion result |
| sos_o | output | 1 | Start-of-sequence flag |
| cfg_o | output | 7 | Echoed configuration |
| err_o | output | 1 | Sticky busy-timeout error |

## Verification
On each of the first eight rising SCK edges the controller both samples a result bit on SDO and presents a programming bit on SDI, so reading and programming share the same edges. A behavioural converter model in the bench returns distinct result patterns while the controller sends several different programming words, including none at all and an all-zero configuration. Each frame is judged twice: the captured result against the scoreboard queue, and the 24 SDI levels the model saw against the expected programming pattern. A start request issued partway through a frame provokes the other overlap, and it is judged by counting convert strobes.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

    localparam int DATA_W  = 16;
    localparam int CFG_W   = 7;
    localparam int CTRL_W  = CFG_W + 1;
    localparam int FRAME_W = DATA_W + 1 + CFG_W;
    localparam int RISE_W  = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNV,
        ST_WAIT,
        ST_FRAME,
        ST_QUIET
    } sar_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sos;
        logic [CFG_W-1:0]  cfg;
    } sar_frame_t;

    function automatic logic [CTRL_W-1:0] ctrl_word(input logic en, input logic [CFG_W-1:0] c);
        return en ? {1'b1, c} : '0;
    endfunction

endpackage

// File: rtl/sar_sck_gen.sv
module sar_sck_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic sck_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick   = run_i && (cnt == CW'(HALF - 1));
    assign rise_o = tick && !sck_o;
    assign fall_o = tick && sck_o;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt   <= '0;
            sck_o <= 1'b0;
        end else begin
            cnt   <= tick ? '0 : cnt + CW'(1);
            sck_o <= sck_o ^ tick;
        end
    end

    // R3: the clock rests low whenever the frame is not running
    p_sck_rest_r3: assert property (@(posedge clk) disable iff (rst) !run_i |=> !sck_o);

endmodule

// File: rtl/sar_frame_shift.sv
module sar_frame_shift
    import sar_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [CTRL_W-1:0] word_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              sck_i,
    input  logic              sdo_i,
    output logic              sdi_o,
    output sar_frame_t        cap_o,
    output logic              done_o
);
    logic [CTRL_W-1:0]  out_sr;
    logic [RISE_W-1:0]  nrise;
    logic [FRAME_W-1:0] in_sr;

    assign done_o = fall_i && (nrise == RISE_W'(FRAME_W));
    assign cap_o  = sar_frame_t'(in_sr);

    always_ff @(posedge clk) begin
        if (rst) begin
            sdi_o  <= 1'b0;
            out_sr <= '0;
            nrise  <= '0;
            in_sr  <= '0;
        end else if (load_i) begin
            sdi_o  <= word_i[CTRL_W-1];
            out_sr <= {word_i[CTRL_W-2:0], 1'b0};
            nrise  <= '0;
        end else begin
            if (rise_i) begin
                in_sr <= {in_sr[FRAME_W-2:0], sdo_i};
                nrise <= nrise + RISE_W'(1);
            end
            if (fall_i) begin
                sdi_o  <= out_sr[CTRL_W-1];
                out_sr <= {out_sr[CTRL_W-2:0], 1'b0};
            end
        end
    end

    // R6: SDI moves only while SCK is low
    p_sdi_sck_low_r6: assert property (@(posedge clk) disable iff (rst) !$stable(sdi_o) |-> !sck_i);
    // R3: never more than one frame of rising edges
    p_rise_bound_r3: assert property (@(posedge clk) disable iff (rst) nrise <= RISE_W'(FRAME_W));

endmodule

// File: rtl/sar_host_ctrl.sv
module sar_host_ctrl
    import sar_host_pkg::*;
#(
    parameter int CNV_CYC   = 4,
    parameter int SCK_HALF  = 2,
    parameter int QUIET_CYC = 4,
    parameter int BUSY_TMO  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              prog_i,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic              busy_i,
    input  logic              sdo_i,
    output logic              cnv_o,
    output logic              sck_o,
    output logic              sdi_o,
    output logic              rd_dis_o,
    output logic              idle_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              sos_o,
    output logic [CFG_W-1:0]  cfg_o,
    output logic              err_o
);
    localparam int MAX_A = (CNV_CYC > QUIET_CYC) ? CNV_CYC : QUIET_CYC;
    localparam int MAX_C = (MAX_A > BUSY_TMO) ? MAX_A : BUSY_TMO;
    localparam int CW    = $clog2(MAX_C + 1);

    sar_state_e        state;
    logic [CW-1:0]     cnt;
    logic              busy_q;
    logic              busy_fall;
    logic [CTRL_W-1:0] word_q;
    sar_frame_t        cap, res_q;
    logic              rise, fall, done, load;

    assign busy_fall = busy_q && !busy_i;
    assign load      = (state == ST_WAIT) && busy_fall;
    assign cnv_o     = (state == ST_CNV);
    assign rd_dis_o  = (state != ST_FRAME);
    assign idle_o    = (state == ST_IDLE);
    assign data_o    = res_q.data;
    assign sos_o     = res_q.sos;
    assign cfg_o     = res_q.cfg;

    sar_sck_gen #(.HALF(SCK_HALF)) sck_gen_i (
        .clk    (clk),
        .rst    (rst),
        .run_i  (state == ST_FRAME),
        .sck_o  (sck_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    sar_frame_shift shift_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .word_i (word_q),
        .rise_i (rise),
        .fall_i (fall),
        .sck_i  (sck_o),
        .sdo_i  (sdo_i),
        .sdi_o  (sdi_o),
        .cap_o  (cap),
        .done_o (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            busy_q  <= 1'b0;
            word_q  <= '0;
            res_q   <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            busy_q  <= busy_i;
            valid_o <= 1'b0;
            unique case (state)
                ST_IDLE: if (start_i) begin
                    state  <= ST_CNV;
                    cnt    <= '0;
                    err_o  <= 1'b0;
                    word_q <= ctrl_word(prog_i, cfg_i);
                end
                ST_CNV: begin
                    cnt <= cnt + CW'(1);
                    if (cnt == CW'(CNV_CYC - 1)) begin
                        state <= ST_WAIT;
                        cnt   <= '0;
                    end
                end
                ST_WAIT: begin
                    cnt <= cnt + CW'(1);
                    if (busy_fall) begin
                        state <= ST_FRAME;
                    end else if (cnt == CW'(BUSY_TMO - 1)) begin
                        state <= ST_IDLE;
                        err_o <= 1'b1;
                    end
                end
                ST_FRAME: if (done) begin
                    state   <= ST_QUIET;
                    cnt     <= '0;
                    res_q   <= cap;
                    valid_o <= 1'b1;
                end
                ST_QUIET: begin
                    cnt <= cnt + CW'(1);
                    if (cnt == CW'(QUIET_CYC - 1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: result strobe lasts a single cycle
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst) valid_o |=> !valid_o);
    // R3: no serial clock while converting
    p_no_sck_cnv_r3: assert property (@(posedge clk) disable iff (rst) cnv_o |-> !sck_o);
    // R9: read lane enabled whenever SCK is high
    p_rd_lane_r9: assert property (@(posedge clk) disable iff (rst) sck_o |-> !rd_dis_o);
    // R8: a timeout lands in idle without a result
    p_tmo_idle_r8: assert property (@(posedge clk) disable iff (rst) $rose(err_o) |-> (idle_o && !valid_o));
    // R7: a convert never directly follows a result strobe
    p_quiet_r7: assert property (@(posedge clk) disable iff (rst) $rose(cnv_o) |-> !$past(valid_o));

endmodule

// File: tb/sar_host_ctrl_tb_top.sv
module sar_host_ctrl_tb_top;
    import sar_host_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CNV_CYC    = 4;
    localparam int SCK_HALF   = 2;
    localparam int QUIET_CYC  = 4;
    localparam int BUSY_TMO   = 64;
    localparam int BUSY_LEN   = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, prog = 1'b0;
    logic [CFG_W-1:0] pcfg = '0;
    logic busy = 1'b0, sdo = 1'b0;
    logic cnv, sck, sdi, rd_dis, idle, valid, sos, err;
    logic [DATA_W-1:0] data;
    logic [CFG_W-1:0] cfg;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sar_host_ctrl #(.CNV_CYC(CNV_CYC), .SCK_HALF(SCK_HALF), .QUIET_CYC(QUIET_CYC), .BUSY_TMO(BUSY_TMO)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .prog_i(prog), .cfg_i(pcfg),
        .busy_i(busy), .sdo_i(sdo), .cnv_o(cnv), .sck_o(sck), .sdi_o(sdi),
        .rd_dis_o(rd_dis), .idle_o(idle), .valid_o(valid), .data_o(data),
        .sos_o(sos), .cfg_o(cfg), .err_o(err)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard queues
    sar_frame_t       adc_q[$];
    sar_frame_t       exp_q[$];
    logic [FRAME_W-1:0] sdi_q[$];

    // converter model state
    bit no_busy = 1'b0;
    int bt = 0, cnv_len = 0, cnv_rises = 0, rises = 0, last_rise = 0, last_valid = -1000, n_valid = 0;
    bit cnv_prev = 1'b0, sck_prev = 1'b0, period_bad = 1'b0;
    logic [FRAME_W-1:0] fw = '0, sdi_cap = '0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (cnv && !cnv_prev) begin
                cnv_rises++;
                cnv_len = 0;
                if (!no_busy) bt = 1;
                chk(cyc - last_valid > QUIET_CYC, "R7", "gap valid->cnv", cyc - last_valid, QUIET_CYC + 1);
            end
            if (cnv) cnv_len++;
            if (!cnv && cnv_prev) chk(cnv_len == CNV_CYC, "R2", "cnv width", cnv_len, CNV_CYC);
            if (bt > 0) begin
                bt++;
                if (bt == 3) busy = 1'b1;
                if (bt == 3 + BUSY_LEN) begin
                    busy = 1'b0; bt = 0;
                    fw = adc_q.pop_front();
                    sdo = fw[FRAME_W-1];
                    rises = 0; sdi_cap = '0; period_bad = 1'b0;
                end
            end
            if (sck && !sck_prev) begin
                if (busy || cnv) chk(1'b0, "R3", "sck rise during busy/cnv", 1, 0);
                if (rd_dis) chk(1'b0, "R9", "read-disable at rise", 1, 0);
                if (rises > 0 && (cyc - last_rise) != 2 * SCK_HALF) period_bad = 1'b1;
                last_rise = cyc;
                sdi_cap = {sdi_cap[FRAME_W-2:0], sdi};
                rises++;
                fw = {fw[FRAME_W-2:0], 1'b0};
                sdo = fw[FRAME_W-1];
                if (rises == FRAME_W) begin
                    logic [FRAME_W-1:0] e;
                    e = sdi_q.pop_front();
                    chk(sdi_cap == e, "R5", "sdi pattern", sdi_cap, e);
                    chk(!period_bad, "R3", "sck period", period_bad, 0);
                end
            end
            // monitor
            if (valid) begin
                n_valid++;
                last_valid = cyc;
                chk(rises == FRAME_W, "R3", "rises per frame", rises, FRAME_W);
                if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected valid", 1, 0);
                else begin
                    sar_frame_t x;
                    x = exp_q.pop_front();
                    chk(data == x.data, "R4", "data", data, x.data);
                    chk({sos, cfg} == {x.sos, x.cfg}, "R4", "sos+cfg", {sos, cfg}, {x.sos, x.cfg});
                end
            end
        end
        cnv_prev = cnv;
        sck_prev = sck;
    end

    task automatic push(input logic [15:0] d, input logic s, input logic [6:0] c, input logic p, input logic [6:0] pc);
        sar_frame_t f;
        f.data = d; f.sos = s; f.cfg = c;
        adc_q.push_back(f);
        exp_q.push_back(f);
        sdi_q.push_back(p ? {1'b1, pc, 16'h0} : '0);
    endtask

    task automatic do_conv(input logic [15:0] d, input logic s, input logic [6:0] c, input logic p, input logic [6:0] pc);
        int nv;
        nv = n_valid;
        push(d, s, c, p, pc);
        @(negedge clk);
        start = 1'b1; prog = p; pcfg = pc;
        @(negedge clk);
        start = 1'b0; prog = 1'b0; pcfg = '0;
        chk(cnv && !err, "R2", "cnv up, err clear (R8)", {cnv, err}, 2'b10);
        while (n_valid == nv) @(negedge clk);
        while (!idle) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({cnv, sck, sdi, valid, err, idle, rd_dis} == 7'b0000011, "R1", "outputs in reset",
            {cnv, sck, sdi, valid, err, idle, rd_dis}, 7'b0000011);
        rst = 1'b0;
        @(negedge clk);
        chk({cnv, sck, sdi, valid, err, idle, rd_dis} == 7'b0000011, "R1", "outputs after reset",
            {cnv, sck, sdi, valid, err, idle, rd_dis}, 7'b0000011);

        do_conv(16'hA5C3, 1'b1, 7'h55, 1'b0, 7'h00);
        do_conv(16'h0001, 1'b0, 7'h7F, 1'b1, 7'h2B);
        do_conv(16'hFFFF, 1'b1, 7'h00, 1'b1, 7'h7F);
        do_conv(16'h8000, 1'b0, 7'h2A, 1'b1, 7'h00);
        chk(idle && rd_dis, "R9", "read-disable high in idle", {idle, rd_dis}, 2'b11);

        // R7: start pulsed again mid-frame is ignored
        begin
            int base;
            base = cnv_rises;
            fork
                do_conv(16'h1234, 1'b1, 7'h11, 1'b0, 7'h00);
                begin
                    while (rises != 5) @(negedge clk);
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
            join
            repeat (30) @(negedge clk);
            chk(cnv_rises == base + 1 && idle, "R7", "mid-frame start ignored", cnv_rises - base, 1);
        end

        // R7: start held high across two conversions keeps the quiet gap
        begin
            int base;
            base = cnv_rises;
            push(16'h5A5A, 1'b0, 7'h33, 1'b1, 7'h4C);
            push(16'h3C3C, 1'b1, 7'h66, 1'b1, 7'h4C);
            @(negedge clk);
            start = 1'b1; prog = 1'b1; pcfg = 7'h4C;
            while (cnv_rises != base + 2) @(negedge clk);
            start = 1'b0; prog = 1'b0;
            while (exp_q.size() != 0) @(negedge clk);
            while (!idle) @(negedge clk);
            chk(cnv_rises == base + 2, "R7", "held start conversions", cnv_rises - base, 2);
        end

        // R8: busy never falls
        begin
            int nv;
            nv = n_valid;
            no_busy = 1'b1;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (CNV_CYC + BUSY_TMO + 10) @(negedge clk);
            chk(err && idle, "R8", "timeout err and idle", {err, idle}, 2'b11);
            chk(n_valid == nv, "R8", "no result on timeout", n_valid - nv, 0);
            no_busy = 1'b0;
        end
        do_conv(16'h0F0F, 1'b1, 7'h0F, 1'b1, 7'h55);
        chk(!err, "R8", "err cleared after restart", err, 0);

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule